// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a free-running timer count and drives one output pin from it. Two compare values are held in the block: a primary value and a secondary value. When the timer count equals a compare value, the block changes the pin level according to the selected mode. It also raises a one-cycle interrupt pulse on the match that completes the mode's action.

The single-compare modes react only to the primary value. They can force the pin high, force it low, or toggle it. The double-compare modes produce a pulse: the primary match moves the pin away from its programmed rest level, and the secondary match brings it back. A double-compare pulse can run once or repeat on every timer cycle. A single-shot pulse can only be started again by writing the control register again.

Software programs the block through one write port that has a select field. Timer counting is qualified by an enable input.

Top module: `ocu_top`

## Requirements
- R1: After reset the pin is 0, the interrupt is 0 and the mode is disabled, so a timer match has no effect.
- R2: A control write (select 0) has these fields: bits [2:0] are the mode and bit 3 is the rest level. On the next cycle the pin equals the rest level and no interrupt is given. A control write takes priority over a match in the same cycle. Select 1 writes the primary value and select 2 writes the secondary value.
- R3: In mode 000, and in the reserved codes 110 and 111, the pin holds the rest level and no interrupt is ever given.
- R4: In mode 001, a primary match drives the pin to 1.
- R5: In mode 010, a primary match drives the pin to 0.
- R6: In mode 011, every primary match inverts the pin.
- R7: In the double modes (100 and 101), a primary match drives the pin to the inverse of the rest level and gives no interrupt. A secondary match returns the pin to the rest level and gives an interrupt.
- R8: In mode 100, once the secondary match has ended the pulse, further matches have no effect until the next control write re-arms the block.
- R9: In mode 101, the pulse repeats on every pass of the timer.
- R10: When the timer enable is 0, no match is recognised.
- R11: In a double mode, when the primary and secondary matches happen in the same cycle, the secondary match wins: the pin is set to the rest level and an interrupt is given.
- R12: The interrupt is a pulse that lasts one cycle. It starts on the clock edge that follows the qualifying match, and the pin changes on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 primary, 2 secondary |
| wr_data | input | TW | Write data |
| tmr_val | input | TW | Timer count |
| tmr_en | input | 1 | Timer count is valid this cycle |
| oc_out | output | 1 | Compare output pin |
| oc_irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong armed state or a wrong mode register shows up at the pin within one cycle of the next match. The visible symptoms are a pulse that repeats after a single-shot has finished, a pulse that never starts, or an interrupt on the wrong compare edge. A wrong pin register shows directly on `oc_out` at the edge after a control write or a match. The bench steps the timer through full passes in every mode and compares the pin and the interrupt on every cycle. Because of this, any such fault is caught at the first match it disturbs.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    typedef enum logic [2:0] {
        OCM_OFF  = 3'd0,
        OCM_HI   = 3'd1,
        OCM_LO   = 3'd2,
        OCM_TGL  = 3'd3,
        OCM_DSS  = 3'd4,
        OCM_DCON = 3'd5,
        OCM_RSV6 = 3'd6,
        OCM_RSV7 = 3'd7
    } ocm_e;

    typedef struct packed {
        logic dflt;
        ocm_e mode;
    } ctrl_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_PRI  = 2'd1;
    localparam logic [1:0] SEL_SEC  = 2'd2;

    function automatic logic is_double(ocm_e m);
        return (m == OCM_DSS) || (m == OCM_DCON);
    endfunction
endpackage

// File: rtl/ocu_regs.sv
module ocu_regs
    import ocu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [TW-1:0] wr_data,
    output logic          ctrl_wr,
    output ctrl_t         wr_ctrl,
    output ctrl_t         ctrl_q,
    output logic [TW-1:0] pri_q,
    output logic [TW-1:0] sec_q
);
    localparam int CW = $bits(ctrl_t);

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign wr_ctrl = ctrl_t'(wr_data[CW-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{dflt: 1'b0, mode: OCM_OFF};
            pri_q  <= '0;
            sec_q  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: ctrl_q <= wr_ctrl;
                SEL_PRI:  pri_q  <= wr_data;
                SEL_SEC:  sec_q  <= wr_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
    parameter int TW = 16
) (
    input  logic [TW-1:0] tmr_val,
    input  logic          tmr_en,
    input  logic [TW-1:0] pri_q,
    input  logic [TW-1:0] sec_q,
    output logic          pri_hit,
    output logic          sec_hit
);
    assign pri_hit = tmr_en && (tmr_val == pri_q);
    assign sec_hit = tmr_en && (tmr_val == sec_q);
endmodule

// File: rtl/ocu_drive.sv
module ocu_drive
    import ocu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_wr,
    input  ctrl_t wr_ctrl,
    input  ctrl_t ctrl_q,
    input  logic  pri_hit,
    input  logic  sec_hit,
    output logic  out_q,
    output logic  irq_q
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= 1'b0;
            irq_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (ctrl_wr) begin
            out_q   <= wr_ctrl.dflt;
            irq_q   <= 1'b0;
            armed_q <= (wr_ctrl.mode != OCM_OFF);
        end else begin
            irq_q <= 1'b0;
            case (ctrl_q.mode)
                OCM_HI: if (pri_hit) begin
                    out_q <= 1'b1;
                    irq_q <= 1'b1;
                end
                OCM_LO: if (pri_hit) begin
                    out_q <= 1'b0;
                    irq_q <= 1'b1;
                end
                OCM_TGL: if (pri_hit) begin
                    out_q <= ~out_q;
                    irq_q <= 1'b1;
                end
                OCM_DSS, OCM_DCON: if (armed_q) begin
                    if (sec_hit) begin
                        out_q <= ctrl_q.dflt;
                        irq_q <= 1'b1;
                        if (ctrl_q.mode == OCM_DSS) armed_q <= 1'b0;
                    end else if (pri_hit) begin
                        out_q <= ~ctrl_q.dflt;
                    end
                end
                default: out_q <= ctrl_q.dflt;
            endcase
        end
    end

    assert_ctrl_default_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (out_q == $past(wr_ctrl.dflt)) && !irq_q);
    assert_off_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == OCM_OFF && !ctrl_wr) |=> (out_q == ctrl_q.dflt) && !irq_q);
    assert_set_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == OCM_HI && pri_hit && !ctrl_wr) |=> out_q && irq_q);
    assert_sec_return_R7: assert property (@(posedge clk) disable iff (rst)
        (is_double(ctrl_q.mode) && armed_q && sec_hit && !ctrl_wr)
        |=> (out_q == ctrl_q.dflt) && irq_q);
    assert_oneshot_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == OCM_DSS && !armed_q && !ctrl_wr) |=> $stable(out_q) && !irq_q);
    assert_irq_cause_R12: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(pri_hit || sec_hit));
endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [TW-1:0] wr_data,
    input  logic [TW-1:0] tmr_val,
    input  logic          tmr_en,
    output logic          oc_out,
    output logic          oc_irq
);
    logic          ctrl_wr;
    ctrl_t         wr_ctrl;
    ctrl_t         ctrl_q;
    logic [TW-1:0] pri_q;
    logic [TW-1:0] sec_q;
    logic          pri_hit;
    logic          sec_hit;

    ocu_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_wr(ctrl_wr), .wr_ctrl(wr_ctrl), .ctrl_q(ctrl_q),
        .pri_q(pri_q), .sec_q(sec_q)
    );

    ocu_match #(.TW(TW)) u_match (
        .tmr_val(tmr_val), .tmr_en(tmr_en), .pri_q(pri_q), .sec_q(sec_q),
        .pri_hit(pri_hit), .sec_hit(sec_hit)
    );

    ocu_drive u_drive (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_ctrl(wr_ctrl), .ctrl_q(ctrl_q),
        .pri_hit(pri_hit), .sec_hit(sec_hit), .out_q(oc_out), .irq_q(oc_irq)
    );
endmodule

// File: tb/ocu_top_bench.sv
`timescale 1ns/1ps
module ocu_top_bench;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [TW-1:0] wr_data = '0;
    logic [TW-1:0] tmr_val = '0;
    logic          tmr_en = 1'b0;
    logic          oc_out;
    logic          oc_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ocu_top #(.TW(TW)) u_ocu_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tmr_val(tmr_val), .tmr_en(tmr_en), .oc_out(oc_out), .oc_irq(oc_irq)
    );

    typedef struct {
        logic  o;
        logic  i;
        string tag;
    } exp_t;
    exp_t q[$];

    // reference state, built from the requirements
    logic [2:0]    m_mode = 3'd0;
    logic          m_dflt = 1'b0;
    logic [TW-1:0] m_pri = '0;
    logic [TW-1:0] m_sec = '0;
    logic          m_armed = 1'b0;
    logic          m_out = 1'b0;

    task automatic step(input bit we, input logic [1:0] sel, input logic [TW-1:0] d,
                        input bit en, input logic [TW-1:0] tv, input string tag);
        logic ph, sh, ei;
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; tmr_en = en; tmr_val = tv;
        ei = 1'b0;
        ph = en && (tv == m_pri);
        sh = en && (tv == m_sec);
        if (we && sel == 2'd0) begin
            m_mode = d[2:0]; m_dflt = d[3]; m_out = d[3]; m_armed = (d[2:0] != 3'd0);
        end else begin
            case (m_mode)
                3'd1: if (ph) begin m_out = 1'b1; ei = 1'b1; end
                3'd2: if (ph) begin m_out = 1'b0; ei = 1'b1; end
                3'd3: if (ph) begin m_out = ~m_out; ei = 1'b1; end
                3'd4, 3'd5: if (m_armed) begin
                    if (sh) begin
                        m_out = m_dflt; ei = 1'b1;
                        if (m_mode == 3'd4) m_armed = 1'b0;
                    end else if (ph) m_out = ~m_dflt;
                end
                default: m_out = m_dflt;
            endcase
            if (we && sel == 2'd1) m_pri = d;
            if (we && sel == 2'd2) m_sec = d;
        end
        q.push_back('{o: m_out, i: ei, tag: tag});
    endtask

    task automatic sweep(input int lo, input int hi, input bit en, input string tag);
        for (int t = lo; t <= hi; t++) step(1'b0, 2'd0, '0, en, TW'(t), tag);
    endtask

    task automatic wctrl(input logic [2:0] mode, input logic dflt, input string tag);
        step(1'b1, 2'd0, TW'({dflt, mode}), 1'b1, '0, tag);
    endtask

    // monitor: pops one expected item per cycle, shortly after the edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (oc_out !== e.o || oc_irq !== e.i) begin
                n_bad++;
                $display("FAIL %s: out/irq = %b/%b, expected %b/%b at t=%0t",
                         e.tag, oc_out, oc_irq, e.o, e.i, $time);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_cmp++;
        if (oc_out !== 1'b0 || oc_irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out/irq = %b/%b, expected 0/0", oc_out, oc_irq);
        end
        sweep(0, 3, 1'b1, "R1");                  // disabled: a match at 0 does nothing
        step(1'b1, 2'd1, 16'd5, 1'b1, 16'd5, "R3");
        step(1'b1, 2'd2, 16'd9, 1'b1, 16'd0, "R3");
        sweep(0, 12, 1'b1, "R3");
        wctrl(3'd1, 1'b0, "R2");
        sweep(0, 15, 1'b1, "R4");
        wctrl(3'd2, 1'b1, "R2");
        sweep(0, 15, 1'b1, "R5");
        wctrl(3'd3, 1'b0, "R2");
        sweep(0, 15, 1'b1, "R6");
        sweep(0, 15, 1'b1, "R12");
        sweep(0, 15, 1'b0, "R10");
        wctrl(3'd4, 1'b0, "R2");
        sweep(0, 15, 1'b1, "R7");
        sweep(0, 15, 1'b1, "R8");
        wctrl(3'd4, 1'b0, "R8");
        sweep(0, 15, 1'b1, "R8");
        wctrl(3'd5, 1'b1, "R2");
        sweep(0, 15, 1'b1, "R9");
        sweep(0, 15, 1'b1, "R9");
        sweep(0, 6, 1'b1, "R9");
        step(1'b1, 2'd0, TW'({1'b1, 3'd5}), 1'b1, 16'd9, "R2"); // write beats sec match
        sweep(10, 15, 1'b1, "R2");
        step(1'b1, 2'd1, 16'd7, 1'b1, 16'd0, "R11");
        step(1'b1, 2'd2, 16'd7, 1'b1, 16'd1, "R11");
        wctrl(3'd5, 1'b0, "R2");
        sweep(0, 15, 1'b1, "R11");
        wctrl(3'd6, 1'b1, "R3");
        sweep(0, 15, 1'b1, "R3");
        wctrl(3'd7, 1'b0, "R3");
        sweep(0, 15, 1'b1, "R3");
        wctrl(3'd0, 1'b1, "R3");
        sweep(0, 15, 1'b1, "R3");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule